// File: doc/BRIEF.md
# FIFO-Fed Serial Transmitter

This block sends bytes on an asynchronous serial line. A host pushes bytes into a sixteen-entry queue through a simple write strobe. While the transmit enable is high, the block removes bytes from the queue one at a time and frames each one. It sends them back to back until the queue runs dry. When the last queued byte is taken, a sticky "queue drained" interrupt is raised. A DMA request line stays high whenever the queue has room for a burst of at least four bytes.

The bit rate comes from three fields: a power-of-two prescale, a multiplier and a divisor. Their product sets the number of system clocks per serial bit. The divided waveform is low for the first half of each period and high for the second half. Its rising edge is turned into a one-cycle tick, so the whole block runs on one clock.

A frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit (even or odd), one high stop bit, and an optional second high stop bit. The frame engine is a state machine with the states IDLE, START, DATA, PARITY, STOP1 and STOP2. Every transition is taken on a bit tick only:
- IDLE→START when the enable is set and the queue holds a byte.
- START→DATA.
- DATA→DATA until the eighth bit is sent.
- DATA→PARITY when parity is on, or DATA→STOP1 when it is off.
- PARITY→STOP1.
- STOP1→STOP2 when a second stop bit is selected.
- STOP1 or STOP2→START when the enable is still set and another byte waits.
- STOP1 or STOP2→IDLE otherwise.

Top module: `fifo_uart_tx`

## Requirements
- R1: After reset `txd` is 1, `irq_empty` is 0, `overflow` is 0 and `dma_req` is 1.
- R2: One serial bit lasts exactly 2^(pre_scale+1) × (bit_mult+1) × bit_div system clocks. The internal bit tick is never high in two consecutive cycles.
- R3: Each frame starts with a 0 start bit. Then come data bits 0 to 7 in that order (bit 0 first), and then a 1 stop bit. The line is 1 whenever no frame is in progress.
- R4: With `parity_en`=1 a parity bit follows data bit 7. Its value is the XOR of the eight data bits when `parity_odd`=0 (even parity), and the inverse of that XOR when `parity_odd`=1 (odd parity).
- R5: With `two_stop`=1 a second 1 stop bit follows the first, so a frame without parity is 11 bit times long.
- R6: While `tx_enable` stays 1, queued bytes are sent in write order. Each next start bit begins exactly where the previous frame's last stop bit ends.
- R7: `irq_empty` becomes 1 when the last queued byte is taken for sending. It stays 1 until a one-cycle `irq_clr` pulse, after which it reads 0.
- R8: `dma_req` is 1 exactly while the queue holds 12 or fewer of its 16 entries.
- R9: A write while the queue holds 16 bytes is dropped and sets `overflow`. The flag stays 1 until an `ovf_clr` pulse.
- R10: Clearing `tx_enable` during a frame lets that frame finish unchanged. No further byte is taken until the enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Push strobe for the transmit queue |
| wr_data | input | 8 | Byte to push |
| tx_enable | input | 1 | Allows frames to start |
| parity_en | input | 1 | Inserts a parity bit |
| parity_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| two_stop | input | 1 | Adds a second stop bit |
| pre_scale | input | 3 | Power-of-two prescale code (factor 2 to 256) |
| bit_mult | input | 5 | Multiplier field (factor bit_mult+1) |
| bit_div | input | 9 | Divisor field |
| irq_clr | input | 1 | Clears the drained interrupt |
| ovf_clr | input | 1 | Clears the overflow flag |
| txd | output | 1 | Serial output |
| irq_empty | output | 1 | Queue-drained interrupt |
| dma_req | output | 1 | Queue has at least four free entries |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
Several kinds of frame are tried:
- A lone byte with bare framing, which shows the start, stop and bit-order placement.
- Bytes with an even and an odd count of ones, under both parity senses. These tell the two senses apart and show that the parity bit is computed rather than fixed.
- Bursts with two stop bits and with parity, where the start-to-start spacing separates 10-, 11- and 12-bit frames and exposes any idle gap between frames.
- A second divider setting, which shows that all three factors take part in the bit time.

A fill of the queue past full followed by a full drain tells a dropped write from a stored one. Dropping the enable mid-frame tells a clean finish from a truncated or continued send.

// File: rtl/utx_pkg.sv
package utx_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_START  = 3'd1,
        S_DATA   = 3'd2,
        S_PARITY = 3'd3,
        S_STOP1  = 3'd4,
        S_STOP2  = 3'd5
    } utx_state_e;
endpackage

// File: rtl/utx_baud_gen.sv
module utx_baud_gen #(
    parameter int PS_W   = 3,
    parameter int MULT_W = 5,
    parameter int DIV_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PS_W-1:0]   pre_scale,
    input  logic [MULT_W-1:0] bit_mult,
    input  logic [DIV_W-1:0]  bit_div,
    output logic              tick
);
    localparam int CNT_W = (1 << PS_W) + 1 + MULT_W + DIV_W;

    logic [CNT_W-1:0] factor_p;
    logic [CNT_W-1:0] product;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] cnt_q;
    logic             bclk_q;
    logic             bclk_d;

    always_comb begin
        factor_p = CNT_W'(2) << pre_scale;
        product  = factor_p * (CNT_W'(bit_mult) + CNT_W'(1)) * CNT_W'(bit_div);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            cnt_q    <= '0;
            bclk_q   <= 1'b0;
            bclk_d   <= 1'b0;
        end else begin
            period_q <= product;
            if (period_q == '0 || cnt_q >= period_q - CNT_W'(1))
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + CNT_W'(1);
            bclk_q <= (period_q != '0) && (cnt_q >= (period_q >> 1));
            bclk_d <= bclk_q;
        end
    end

    assign tick = bclk_q & ~bclk_d;

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
endmodule

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DW-1:0]              push_data,
    input  logic                       pop,
    input  logic                       ovf_clr,
    output logic [DW-1:0]              head,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       empty,
    output logic                       full,
    output logic                       overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push_ok;
    logic          pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
            count <= count + CW'(push_ok) - CW'(pop_ok);
            if (push & full)  overflow <= 1'b1;
            else if (ovf_clr) overflow <= 1'b0;
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> overflow); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (count <= CW'(DEPTH))); // R9
endmodule

// File: rtl/utx_frame_fsm.sv
module utx_frame_fsm
    import utx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          enable,
    input  logic          parity_en,
    input  logic          parity_odd,
    input  logic          two_stop,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_head,
    output logic          pop,
    output logic          txd
);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

    utx_state_e    state, nxt;
    logic [DW-1:0] shreg;
    logic [BW-1:0] bitcnt;
    logic          par_bit;
    logic          go;

    assign go  = enable & ~fifo_empty;
    assign pop = tick && (nxt == S_START);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   nxt = go ? S_START : S_IDLE;
            S_START:  nxt = S_DATA;
            S_DATA:   if (bitcnt == LAST_BIT) nxt = parity_en ? S_PARITY : S_STOP1;
            S_PARITY: nxt = S_STOP1;
            S_STOP1:  nxt = two_stop ? S_STOP2 : (go ? S_START : S_IDLE);
            S_STOP2:  nxt = go ? S_START : S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= S_IDLE;
        else if (tick) state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd     <= 1'b1;
            shreg   <= '0;
            bitcnt  <= '0;
            par_bit <= 1'b0;
        end else if (tick) begin
            unique case (nxt)
                S_START: begin
                    txd     <= 1'b0;
                    shreg   <= fifo_head;
                    par_bit <= (^fifo_head) ^ parity_odd;
                    bitcnt  <= '0;
                end
                S_DATA: begin
                    if (state == S_START) begin
                        txd <= shreg[0];
                    end else begin
                        txd    <= shreg[1];
                        shreg  <= shreg >> 1;
                        bitcnt <= bitcnt + BW'(1);
                    end
                end
                S_PARITY: txd <= par_bit;
                default:  txd <= 1'b1;
            endcase
        end
    end

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START) |-> !txd); // R3
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> txd); // R3
    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP1 || state == S_STOP2) |-> txd); // R5
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !fifo_empty); // R6
endmodule

// File: rtl/fifo_uart_tx.sv
module fifo_uart_tx #(
    parameter int DW       = 8,
    parameter int DEPTH    = 16,
    parameter int DMA_FREE = 4,
    parameter int PS_W     = 3,
    parameter int MULT_W   = 5,
    parameter int DIV_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DW-1:0]     wr_data,
    input  logic              tx_enable,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              two_stop,
    input  logic [PS_W-1:0]   pre_scale,
    input  logic [MULT_W-1:0] bit_mult,
    input  logic [DIV_W-1:0]  bit_div,
    input  logic              irq_clr,
    input  logic              ovf_clr,
    output logic              txd,
    output logic              irq_empty,
    output logic              dma_req,
    output logic              overflow
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic          tick;
    logic          pop;
    logic [DW-1:0] head;
    logic [CW-1:0] count;
    logic          empty;
    logic          full;
    logic          irq_set;

    utx_baud_gen #(.PS_W(PS_W), .MULT_W(MULT_W), .DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .pre_scale(pre_scale), .bit_mult(bit_mult),
        .bit_div(bit_div), .tick(tick)
    );

    utx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_valid), .push_data(wr_data),
        .pop(pop), .ovf_clr(ovf_clr), .head(head), .count(count),
        .empty(empty), .full(full), .overflow(overflow)
    );

    utx_frame_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(tx_enable),
        .parity_en(parity_en), .parity_odd(parity_odd), .two_stop(two_stop),
        .fifo_empty(empty), .fifo_head(head), .pop(pop), .txd(txd)
    );

    assign irq_set = pop && (count == CW'(1)) && !(wr_valid && !full);
    assign dma_req = (CW'(DEPTH) - count) >= CW'(DMA_FREE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_empty <= 1'b0;
        else if (irq_set) irq_empty <= 1'b1;
        else if (irq_clr) irq_empty <= 1'b0;
    end

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !irq_set) |=> !irq_empty); // R7
    AST_IRQ_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> (irq_empty && empty)); // R7
endmodule

// File: tb/fifo_uart_tx_test.sv
module fifo_uart_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tx_enable = 1'b0;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic [2:0] pre_scale = 3'd0;
    logic [4:0] bit_mult = 5'd1;
    logic [8:0] bit_div = 9'd3;
    logic       irq_clr = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       txd, irq_empty, dma_req, overflow;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int bitp = 12;

    fifo_uart_tx uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .tx_enable(tx_enable), .parity_en(parity_en), .parity_odd(parity_odd),
        .two_stop(two_stop), .pre_scale(pre_scale), .bit_mult(bit_mult),
        .bit_div(bit_div), .irq_clr(irq_clr), .ovf_clr(ovf_clr), .txd(txd),
        .irq_empty(irq_empty), .dma_req(dma_req), .overflow(overflow)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); wr_valid = 1'b1; wr_data = b;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic pulse_irq_clr();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic wait_start(input int limit, output int t, output bit found);
        found = 1'b0; t = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (txd == 1'b0) begin found = 1'b1; t = cyc; break; end
        end
    endtask

    task automatic recv(input logic [7:0] exp, input string req, input bit drop,
                        output int tstart);
        bit found;
        logic [7:0] got;
        logic expar;
        wait_start(40 * bitp, tstart, found);
        chk({req, " start seen"}, int'(found), 1);
        repeat (bitp / 2) @(negedge clk);
        chk({req, " start bit"}, int'(txd), 0);
        for (int i = 0; i < 8; i++) begin
            repeat (bitp) @(negedge clk);
            got[i] = txd;
            if (drop && i == 3) tx_enable = 1'b0;
        end
        chk({req, " data"}, int'(got), int'(exp));
        if (parity_en) begin
            expar = (^exp) ^ parity_odd;
            repeat (bitp) @(negedge clk);
            chk({req, " R4 parity"}, int'(txd), int'(expar));
        end
        repeat (bitp) @(negedge clk);
        chk({req, " stop1"}, int'(txd), 1);
        if (two_stop) begin
            repeat (bitp) @(negedge clk);
            chk({req, " R5 stop2"}, int'(txd), 1);
        end
    endtask

    task automatic quiet(input int ncyc, input string req);
        int lows = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        chk({req, " line stays idle"}, lows, 0);
    endtask

    task automatic t_reset();
        chk("R1 txd", int'(txd), 1);
        chk("R1 irq_empty", int'(irq_empty), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 dma_req", int'(dma_req), 1);
    endtask

    task automatic t_basic();
        int t0;
        push(8'hA5);
        @(negedge clk); tx_enable = 1'b1;
        recv(8'hA5, "R3 basic", 1'b0, t0);
        tx_enable = 1'b0;
        quiet(3 * bitp, "R3 after frame");
    endtask

    task automatic t_parity();
        int t0;
        parity_en = 1'b1; parity_odd = 1'b0;
        push(8'hA5); push(8'h07);
        @(negedge clk); tx_enable = 1'b1;
        recv(8'hA5, "R4 even a5", 1'b0, t0);
        recv(8'h07, "R4 even 07", 1'b0, t0);
        tx_enable = 1'b0;
        quiet(2 * bitp, "R4");
        parity_odd = 1'b1;
        push(8'h07); push(8'h3C);
        @(negedge clk); tx_enable = 1'b1;
        recv(8'h07, "R4 odd 07", 1'b0, t0);
        recv(8'h3C, "R4 odd 3c", 1'b0, t0);
        tx_enable = 1'b0;
        quiet(2 * bitp, "R4");
        parity_en = 1'b0; parity_odd = 1'b0;
    endtask

    task automatic t_two_stop();
        int t0, t1;
        two_stop = 1'b1;
        push(8'h3C); push(8'hC3);
        @(negedge clk); tx_enable = 1'b1;
        recv(8'h3C, "R5 first", 1'b0, t0);
        recv(8'hC3, "R5 second", 1'b0, t1);
        chk("R5 R6 frame spacing", t1 - t0, 11 * bitp);
        tx_enable = 1'b0;
        quiet(2 * bitp, "R5");
        two_stop = 1'b0;
    endtask

    task automatic t_burst_irq();
        int t0, t1, t2;
        pulse_irq_clr();
        chk("R7 cleared before burst", int'(irq_empty), 0);
        parity_en = 1'b1;
        push(8'h11); push(8'h22); push(8'h33);
        @(negedge clk); tx_enable = 1'b1;
        recv(8'h11, "R6 burst0", 1'b0, t0);
        chk("R7 no irq with 2 queued", int'(irq_empty), 0);
        recv(8'h22, "R6 burst1", 1'b0, t1);
        chk("R7 no irq with 1 queued", int'(irq_empty), 0);
        recv(8'h33, "R6 burst2", 1'b0, t2);
        chk("R6 spacing 0-1", t1 - t0, 11 * bitp);
        chk("R6 spacing 1-2", t2 - t1, 11 * bitp);
        chk("R7 irq after drain", int'(irq_empty), 1);
        tx_enable = 1'b0;
        quiet(2 * bitp, "R6");
        chk("R7 irq sticky", int'(irq_empty), 1);
        pulse_irq_clr();
        chk("R7 irq after clear", int'(irq_empty), 0);
        parity_en = 1'b0;
    endtask

    task automatic t_baud();
        int t0, t1;
        pre_scale = 3'd1; bit_mult = 5'd0; bit_div = 9'd5;
        bitp = 20;
        repeat (50) @(negedge clk);
        push(8'h5A); push(8'h96);
        @(negedge clk); tx_enable = 1'b1;
        recv(8'h5A, "R2 baud20 a", 1'b0, t0);
        recv(8'h96, "R2 baud20 b", 1'b0, t1);
        chk("R2 bit time 20", t1 - t0, 10 * 20);
        tx_enable = 1'b0;
        quiet(2 * bitp, "R2");
        pre_scale = 3'd0; bit_mult = 5'd1; bit_div = 9'd3;
        bitp = 12;
        repeat (50) @(negedge clk);
    endtask

    task automatic t_overflow();
        int t0, tp;
        for (int i = 0; i < 12; i++) push(8'h40 + 8'(i));
        @(negedge clk);
        chk("R8 dma at 12 queued", int'(dma_req), 1);
        push(8'h4C);
        @(negedge clk);
        chk("R8 dma at 13 queued", int'(dma_req), 0);
        for (int i = 13; i < 16; i++) push(8'h40 + 8'(i));
        @(negedge clk);
        chk("R9 no overflow at full", int'(overflow), 0);
        push(8'hEE);
        @(negedge clk);
        chk("R9 overflow set", int'(overflow), 1);
        repeat (5) @(negedge clk);
        chk("R9 overflow sticky", int'(overflow), 1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk("R9 overflow cleared", int'(overflow), 0);
        tx_enable = 1'b1;
        tp = 0;
        for (int i = 0; i < 16; i++) begin
            recv(8'h40 + 8'(i), "R9 drain", 1'b0, t0);
            if (i > 0) chk("R6 drain spacing", t0 - tp, 10 * bitp);
            tp = t0;
        end
        quiet(25 * bitp, "R9 dropped byte not sent");
        chk("R8 dma after drain", int'(dma_req), 1);
        tx_enable = 1'b0;
    endtask

    task automatic t_enable_drop();
        int t0;
        push(8'hB4); push(8'h2D);
        @(negedge clk); tx_enable = 1'b1;
        recv(8'hB4, "R10 frame finishes", 1'b1, t0);
        quiet(30 * bitp, "R10 no next frame");
        tx_enable = 1'b1;
        recv(8'h2D, "R10 held byte", 1'b0, t0);
        tx_enable = 1'b0;
        quiet(2 * bitp, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        repeat (30) @(negedge clk);
        t_basic();
        t_parity();
        t_two_stop();
        t_burst_irq();
        t_baud();
        t_overflow();
        t_enable_drop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule